// File: doc/BRIEF.md
# Cross-Port Mailbox Interrupt Flags

This block sits beside a two-port shared memory and produces one interrupt flag for each port. Each port owns a mailbox word near the top of the address space. Port L owns the word at all-ones minus one (0x3FFE for 14 address bits), and port R owns the all-ones word (0x3FFF). When one port writes the other port's mailbox word, the other port's interrupt flag is raised. The flag drops when its owner reads its own mailbox word. The block only watches the normal access strobes. The mailbox words stay ordinary storage in the memory array, which lies outside this block.

Each port supplies its chip enable, write enable, output enable, address and busy (write-inhibit) state, all active low except the address. A port whose busy input is low cannot raise or drop any flag. Both interrupt outputs are active low and always driven. A flag changes on the clock edge that samples the qualifying access, so each access must be exactly one cycle wide. Reset is asserted asynchronously and released synchronously inside the block.

Top module: `mbx_irq`

## Requirements
- R1: While reset is applied, and after it is released with no accesses, both `l_irq_n` and `r_irq_n` are high (inactive).
- R2: A cycle with `r_cs_n`=0, `r_we_n`=0, `r_addr`=0x3FFE and `r_busy_n`=1 drives `l_irq_n` low from the following clock edge.
- R3: A cycle with `l_cs_n`=0, `l_oe_n`=0, `l_addr`=0x3FFE and `l_busy_n`=1 returns `l_irq_n` high from the following edge. The value of `l_we_n` does not matter.
- R4: A cycle with `l_cs_n`=0, `l_we_n`=0, `l_addr`=0x3FFF and `l_busy_n`=1 drives `r_irq_n` low from the following edge.
- R5: A cycle with `r_cs_n`=0, `r_oe_n`=0, `r_addr`=0x3FFF and `r_busy_n`=1 returns `r_irq_n` high from the following edge. The value of `r_we_n` does not matter.
- R6: While a port's busy input is low, that port's accesses neither set nor clear any flag.
- R7: If a set and a clear of the same flag fall in the same cycle, the flag ends up set (output low).
- R8: The following leave both flags unchanged: accesses to any other address, accesses with chip enable high, a port's write to its own mailbox with output enable high, and a port's read of the other port's mailbox.
- R9: Setting or clearing one flag never changes the other flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| l_cs_n | input | 1 | Port L chip enable, active low |
| l_we_n | input | 1 | Port L write enable, active low |
| l_oe_n | input | 1 | Port L output enable, active low |
| l_addr | input | 14 | Port L word address |
| l_busy_n | input | 1 | Port L busy, low blocks its flag effects |
| r_cs_n | input | 1 | Port R chip enable, active low |
| r_we_n | input | 1 | Port R write enable, active low |
| r_oe_n | input | 1 | Port R output enable, active low |
| r_addr | input | 14 | Port R word address |
| r_busy_n | input | 1 | Port R busy, low blocks its flag effects |
| l_irq_n | output | 1 | Port L interrupt, active low |
| r_irq_n | output | 1 | Port R interrupt, active low |

## Verification
Each flag has a single register between the access and the pin, so every result is due one clock edge after the cycle that carries the access. The driver applies one access per cycle on the falling edge and queues the flag values the requirements predict for that access. The monitor samples the outputs 1 ns after the next rising edge and pops one expectation per cycle, so each comparison lines up with the edge that should have produced it. Reset release takes two extra edges because of the synchronizer, and the bench waits for that before its first access.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NPORT  = 2;
  localparam int PORT_L = 0;
  localparam int PORT_R = 1;

  // Offset below the all-ones address for each port's own mailbox word
  function automatic int mbx_offset(input int port);
    return (port == PORT_L) ? 1 : 0;
  endfunction

  function automatic int peer_of(input int port);
    return (port == PORT_L) ? PORT_R : PORT_L;
  endfunction
endpackage

// File: rtl/mbx_rst_sync.sv
module mbx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/mbx_port_decode.sv
module mbx_port_decode #(
  parameter int                ADDR_W    = 14,
  parameter logic [ADDR_W-1:0] OWN_ADDR  = '1,
  parameter logic [ADDR_W-1:0] PEER_ADDR = '1
) (
  input  logic              cs_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic              busy_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              set_peer,
  output logic              clr_own
);
  logic sel;
  logic hit_own;
  logic hit_peer;

  always_comb begin
    sel      = !cs_n && busy_n;
    hit_own  = (addr == OWN_ADDR);
    hit_peer = (addr == PEER_ADDR);
    set_peer = sel && !we_n && hit_peer;
    clr_own  = sel && !oe_n && hit_own;
  end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic irq_n
);
  logic flag_q;
  logic flag_d;
  logic flag_en;

  always_comb begin
    flag_en = set || clr;
    flag_d  = set || (flag_q && !clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  assign irq_n = !flag_q;

  // R7: set wins over clear in the same cycle
  p_set_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> !irq_n);
  // R3 / R5: lone clear drops the flag
  p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> irq_n);
  // R8: no request, no change
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!set && !clr) |=> $stable(irq_n));
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
  parameter int ADDR_W      = 14,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_cs_n,
  input  logic              l_we_n,
  input  logic              l_oe_n,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_busy_n,
  input  logic              r_cs_n,
  input  logic              r_we_n,
  input  logic              r_oe_n,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_busy_n,
  output logic              l_irq_n,
  output logic              r_irq_n
);
  import mbx_pkg::*;

  localparam logic [ADDR_W-1:0] TOP_ADDR = '1;

  logic              rst_n_sync;
  logic [NPORT-1:0]  cs_n, we_n, oe_n, busy_n;
  logic [ADDR_W-1:0] addr [NPORT];
  logic [NPORT-1:0]  set_from;   // set request raised by port p for its peer
  logic [NPORT-1:0]  clr_own;    // clear request by port p for itself
  logic [NPORT-1:0]  irq_n;

  mbx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  always_comb begin
    cs_n[PORT_L]   = l_cs_n;   cs_n[PORT_R]   = r_cs_n;
    we_n[PORT_L]   = l_we_n;   we_n[PORT_R]   = r_we_n;
    oe_n[PORT_L]   = l_oe_n;   oe_n[PORT_R]   = r_oe_n;
    busy_n[PORT_L] = l_busy_n; busy_n[PORT_R] = r_busy_n;
    addr[PORT_L]   = l_addr;   addr[PORT_R]   = r_addr;
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    localparam int PEER = peer_of(p);
    localparam logic [ADDR_W-1:0] OWN_A  = TOP_ADDR - ADDR_W'(mbx_offset(p));
    localparam logic [ADDR_W-1:0] PEER_A = TOP_ADDR - ADDR_W'(mbx_offset(PEER));

    mbx_port_decode #(
      .ADDR_W    (ADDR_W),
      .OWN_ADDR  (OWN_A),
      .PEER_ADDR (PEER_A)
    ) u_dec (
      .cs_n     (cs_n[p]),
      .we_n     (we_n[p]),
      .oe_n     (oe_n[p]),
      .busy_n   (busy_n[p]),
      .addr     (addr[p]),
      .set_peer (set_from[p]),
      .clr_own  (clr_own[p])
    );

    mbx_flag u_flag (
      .clk   (clk),
      .rst_n (rst_n_sync),
      .set   (set_from[PEER]),
      .clr   (clr_own[p]),
      .irq_n (irq_n[p])
    );
  end

  assign l_irq_n = irq_n[PORT_L];
  assign r_irq_n = irq_n[PORT_R];

  // R6: a busy port can neither raise the peer flag nor drop its own
  p_busy_noset_l_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !r_busy_n |=> !$fell(l_irq_n));
  p_busy_noset_r_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !l_busy_n |=> !$fell(r_irq_n));
  p_busy_noclr_l_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !l_busy_n |=> !$rose(l_irq_n));
  p_busy_noclr_r_r6: assert property (@(posedge clk) disable iff (!rst_n_sync)
    !r_busy_n |=> !$rose(r_irq_n));
  // R9: an idle peer cannot raise a flag
  p_idle_peer_r9: assert property (@(posedge clk) disable iff (!rst_n_sync)
    r_cs_n |=> !$fell(l_irq_n));
endmodule

// File: tb/mbx_irq_test.sv
module mbx_irq_test;
  localparam int AW = 14;
  localparam logic [AW-1:0] MB_L = 14'h3FFE;
  localparam logic [AW-1:0] MB_R = 14'h3FFF;

  logic clk = 1'b0;
  logic rst_n;
  logic l_cs_n, l_we_n, l_oe_n, l_busy_n;
  logic r_cs_n, r_we_n, r_oe_n, r_busy_n;
  logic [AW-1:0] l_addr, r_addr;
  logic l_irq_n, r_irq_n;

  int checks = 0;
  int errors = 0;
  logic model_l = 1'b0;
  logic model_r = 1'b0;
  logic [1:0] exp_q [$];
  string      tag_q [$];
  bit         done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mbx_irq #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n),
    .l_cs_n(l_cs_n), .l_we_n(l_we_n), .l_oe_n(l_oe_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
    .r_cs_n(r_cs_n), .r_we_n(r_we_n), .r_oe_n(r_oe_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
    .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
  );

  // Driver: one access per cycle on both ports, expectation pushed to the scoreboard
  task automatic step(
    input logic lc, input logic lw, input logic lo, input logic [AW-1:0] la, input logic lb,
    input logic rc, input logic rw, input logic ro, input logic [AW-1:0] ra, input logic rb,
    input string tag);
    logic lset, lclr, rset, rclr;
    @(negedge clk);
    l_cs_n = lc; l_we_n = lw; l_oe_n = lo; l_addr = la; l_busy_n = lb;
    r_cs_n = rc; r_we_n = rw; r_oe_n = ro; r_addr = ra; r_busy_n = rb;
    lset = !rc && !rw && ra == MB_L && rb;
    lclr = !lc && !lo && la == MB_L && lb;
    rset = !lc && !lw && la == MB_R && lb;
    rclr = !rc && !ro && ra == MB_R && rb;
    model_l = lset || (model_l && !lclr);
    model_r = rset || (model_r && !rclr);
    exp_q.push_back({!model_l, !model_r});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input string tag);
    step(1, 1, 1, '0, 1, 1, 1, 1, '0, 1, tag);
  endtask

  // Monitor: compare 1 ns after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        checks++;
        if ({l_irq_n, r_irq_n} !== e) begin
          errors++;
          $display("FAIL %s: {l_irq_n,r_irq_n} actual %b expected %b", t, {l_irq_n, r_irq_n}, e);
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    l_cs_n = 1; l_we_n = 1; l_oe_n = 1; l_addr = '0; l_busy_n = 1;
    r_cs_n = 1; r_we_n = 1; r_oe_n = 1; r_addr = '0; r_busy_n = 1;
    repeat (3) @(posedge clk);
    #1;
    checks++;  // R1 during reset
    if ({l_irq_n, r_irq_n} !== 2'b11) begin
      errors++;
      $display("FAIL R1 in reset: actual %b expected 11", {l_irq_n, r_irq_n});
    end
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    idle("R1 after release");

    // R2: right writes 0x3FFE
    step(1, 1, 1, '0, 1,   0, 0, 1, MB_L, 1, "R2 set left");
    idle("R2 hold");
    // R8: neutral accesses
    step(0, 0, 1, MB_L, 1, 1, 1, 1, '0, 1, "R8 left writes own mailbox, oe high");
    step(0, 1, 0, MB_R, 1, 1, 1, 1, '0, 1, "R8 left reads peer mailbox");
    step(1, 0, 0, MB_R, 1, 0, 1, 0, MB_L, 1, "R8 cs high left, right reads peer mailbox");
    step(0, 0, 0, 14'h3FFD, 1, 0, 0, 0, 14'h0001, 1, "R8 other addresses");
    // R3: left reads 0x3FFE with we low
    step(0, 0, 0, MB_L, 1, 1, 1, 1, '0, 1, "R3 clear left, we low");
    // R4 + R9: left writes 0x3FFF
    step(0, 0, 1, MB_R, 1, 1, 1, 1, '0, 1, "R4 set right, R9 left unchanged");
    // R6: busy blocks clear and set
    step(1, 1, 1, '0, 1, 0, 1, 0, MB_R, 0, "R6 busy right blocks clear");
    step(1, 1, 1, '0, 1, 0, 0, 1, MB_L, 0, "R6 busy right blocks set");
    // R5: right reads 0x3FFF
    step(1, 1, 1, '0, 1, 0, 1, 0, MB_R, 1, "R5 clear right");
    step(1, 1, 1, '0, 1, 0, 0, 1, MB_L, 1, "R2 set left again");
    step(0, 1, 0, MB_L, 0, 1, 1, 1, '0, 1, "R6 busy left blocks clear");
    step(0, 0, 1, MB_R, 0, 1, 1, 1, '0, 1, "R6 busy left blocks set");
    // R7: simultaneous set and clear
    step(0, 1, 0, MB_L, 1, 0, 0, 1, MB_L, 1, "R7 left set wins");
    step(0, 0, 1, MB_R, 1, 0, 0, 0, MB_R, 1, "R7 right set wins");
    step(0, 1, 0, MB_L, 1, 0, 1, 0, MB_R, 1, "R3 R5 both cleared");
    idle("R9 final idle");
    @(posedge clk); #2;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule